// File: doc/BRIEF.md
# Continuous-Phase MSK Transmit Modulator

This block converts a serial bit stream into a digital minimum-shift-keyed waveform whose phase never breaks. It divides a master clock down to a transmit bit clock, which it drives out so that upstream logic can present each new data bit after a rising edge. It samples that bit on the rising edge and applies it from the start of the following bit period. A 24-bit phase accumulator advances by one of two per-cycle increments. A mark advances the phase by exactly one tone cycle per bit and a space by one and a half, which gives modulation index 0.5. The top bits of the accumulator address a computed 256-entry signed sine table.

The bit period follows from two inputs together. One says which master-clock frequency is fitted and the other picks the faster or slower rate. A start-phase input selects sine or cosine phase at reset. The registered output normally carries the sine table value. Two mode inputs can replace it with a full-scale copy of the raw data level, or with an external audio sample stream. In both of those modes the accumulator keeps running underneath.

Top module: `msk_tx_mod`

## Requirements
- R1: A synchronous reset (rst high) clears the bit counter and forces tx_clk low and sample_out to 0. Both the bit being sent and the captured bit are set to 1 (mark).
- R2: The bit period N is 2*BASE_PERIOD when clk_sel=1 and rate_sel=0, and BASE_PERIOD otherwise (BASE_PERIOD defaults to 3072). tx_clk is low for the first N/2 cycles of each period and high for the last N/2.
- R3: tx_data is captured at the clock edge on which tx_clk rises. The captured value becomes the bit being sent at the edge that starts the next period, which is the edge on which tx_clk falls.
- R4: Within a period the accumulator adds round(2^24/N) per cycle while sending a 1, and round(3*2^23/N) per cycle while sending a 0.
- R5: At each period start the accumulator is loaded with the previous period-start phase. A 0 (space) adds 2^23 to that phase, modulo 2^24, and a 1 (mark) adds nothing. This keeps the phase continuous, with only rounding error at the boundary.
- R6: With mod_en=1 and preset_sel=1, sample_out equals T[a] one cycle after the accumulator holds a, where a is its top 8 bits. T is defined with t=i mod 128, u=t*(128-t) and m=floor(508*u/(20480-u)). T[i]=m for i<128 and T[i]=-m otherwise.
- R7: At reset the accumulator is loaded with 0 when sin_sel=1 and with 2^22 when sin_sel=0. The first sample after reset is therefore 0 for sine phase and 127 for cosine phase.
- R8: With mod_en=1 and preset_sel=0, sample_out is +127 one cycle after tx_data=1 and -127 one cycle after tx_data=0. The accumulator keeps advancing.
- R9: With mod_en=0, sample_out equals audio_in delayed by one cycle. The accumulator keeps advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 1 | 1: fast master clock fitted, 0: slow master clock |
| rate_sel | input | 1 | With clk_sel=1: 1 fast rate, 0 half rate |
| sin_sel | input | 1 | Start phase at reset: 1 sine, 0 cosine |
| preset_sel | input | 1 | 0: raw data level replaces the waveform |
| mod_en | input | 1 | 1: modulator drives output, 0: audio passthrough |
| tx_data | input | 1 | Serial send data |
| audio_in | input | 8 | Signed external audio sample |
| tx_clk | output | 1 | Transmit bit clock |
| sample_out | output | 8 | Signed output sample |

## Verification
A period boundary loads the accumulator from the stored start phase. In the same cycle the output path may be switching between waveform, raw level and audio. The bench toggles mod_en and preset_sel at random points, so some toggles land on boundary cycles. It judges every output sample against a bench model whose accumulator runs in all modes. A waveform resumed after a mode switch must therefore carry the phase implied by every bit sent in between.

// File: rtl/msk_tx_mod.sv
module msk_tx_mod #(
  parameter int BASE_PERIOD = 3072,
  parameter int ACC_W = 24,
  parameter int ADDR_W = 8,
  parameter int AMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_sel,
  input  logic                    rate_sel,
  input  logic                    sin_sel,
  input  logic                    preset_sel,
  input  logic                    mod_en,
  input  logic                    tx_data,
  input  logic signed [AMP_W-1:0] audio_in,
  output logic                    tx_clk,
  output logic signed [AMP_W-1:0] sample_out
);

  localparam int SLOW_PERIOD = 2 * BASE_PERIOD;
  localparam int CNT_W = $clog2(SLOW_PERIOD);
  localparam int ROM_N = 1 << ADDR_W;
  localparam longint TURN = longint'(1) << ACC_W;
  localparam logic [ACC_W-1:0] MARK_F  = ACC_W'((TURN + BASE_PERIOD / 2) / BASE_PERIOD);
  localparam logic [ACC_W-1:0] SPACE_F = ACC_W'((3 * TURN / 2 + BASE_PERIOD / 2) / BASE_PERIOD);
  localparam logic [ACC_W-1:0] MARK_S  = ACC_W'((TURN + SLOW_PERIOD / 2) / SLOW_PERIOD);
  localparam logic [ACC_W-1:0] SPACE_S = ACC_W'((3 * TURN / 2 + SLOW_PERIOD / 2) / SLOW_PERIOD);
  localparam logic [ACC_W-1:0] HALF_TURN = ACC_W'(TURN / 2);
  localparam logic [ACC_W-1:0] QUARTER   = ACC_W'(TURN / 4);
  localparam logic [CNT_W:0] LAST_F = (CNT_W+1)'(BASE_PERIOD - 1);
  localparam logic [CNT_W:0] LAST_S = (CNT_W+1)'(SLOW_PERIOD - 1);
  localparam logic [CNT_W:0] HALF_F = (CNT_W+1)'(BASE_PERIOD / 2);
  localparam logic [CNT_W:0] HALF_S = (CNT_W+1)'(BASE_PERIOD);
  localparam longint PEAK = (longint'(1) << (AMP_W - 1)) - 1;

  function automatic logic [ROM_N*AMP_W-1:0] build_rom();
    logic [ROM_N*AMP_W-1:0] r;
    longint h, t, u, m;
    r = '0;
    h = ROM_N / 2;
    for (int i = 0; i < ROM_N; i++) begin
      t = i % h;
      u = t * (h - t);
      m = (4 * PEAK * u) / ((5 * h * h) / 4 - u);
      r[i*AMP_W +: AMP_W] = (i < h) ? AMP_W'(m) : AMP_W'(-m);
    end
    return r;
  endfunction

  localparam logic [ROM_N*AMP_W-1:0] SINE_ROM = build_rom();

  logic [CNT_W-1:0] cnt;
  logic             hold_bit, cur_bit;
  logic [ACC_W-1:0] base_ph, phase_acc;

  wire             slow      = clk_sel & ~rate_sel;
  wire [CNT_W:0]   last_cnt  = slow ? LAST_S : LAST_F;
  wire [CNT_W:0]   half_cnt  = slow ? HALF_S : HALF_F;
  wire             wrap      = {1'b0, cnt} >= last_cnt;
  wire             capture   = {1'b0, cnt} == (half_cnt - 1'b1);
  wire [ACC_W-1:0] step      = cur_bit ? (slow ? MARK_S : MARK_F) : (slow ? SPACE_S : SPACE_F);
  wire [ACC_W-1:0] next_base = base_ph + (cur_bit ? '0 : HALF_TURN);
  wire [ADDR_W-1:0] rom_addr = phase_acc[ACC_W-1 -: ADDR_W];
  wire signed [AMP_W-1:0] wave = SINE_ROM[int'(rom_addr)*AMP_W +: AMP_W];
  wire signed [AMP_W-1:0] level = tx_data ? AMP_W'(PEAK) : AMP_W'(-PEAK);

  assign tx_clk = {1'b0, cnt} >= half_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      hold_bit   <= 1'b1;
      cur_bit    <= 1'b1;
      base_ph    <= sin_sel ? '0 : QUARTER;
      phase_acc  <= sin_sel ? '0 : QUARTER;
      sample_out <= '0;
    end else begin
      if (capture) hold_bit <= tx_data;
      if (wrap) begin
        cnt       <= '0;
        cur_bit   <= hold_bit;
        base_ph   <= next_base;
        phase_acc <= next_base;
      end else begin
        cnt       <= cnt + 1'b1;
        phase_acc <= phase_acc + step;
      end
      sample_out <= !mod_en ? audio_in : (!preset_sel ? level : wave);
    end
  end

endmodule

module msk_tx_mod_chk #(
  parameter int ACC_W = 24,
  parameter int AMP_W = 8,
  parameter longint MAX_STEP = 8192
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mod_en,
  input logic                    preset_sel,
  input logic                    tx_data,
  input logic signed [AMP_W-1:0] audio_in,
  input logic                    tx_clk,
  input logic signed [AMP_W-1:0] sample_out,
  input logic [ACC_W-1:0]        phase_acc
);

  logic [ACC_W-1:0] prev_acc;
  always_ff @(posedge clk) prev_acc <= phase_acc;
  wire [ACC_W-1:0] ph_delta = phase_acc - prev_acc;

  a_r1_clk_low_after_reset: assert property (@(posedge clk) rst |=> !tx_clk);

  a_r2_clk_high_min: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_clk) |=> tx_clk);

  a_r2_clk_low_min: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_clk) |=> !tx_clk);

  a_r5_phase_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ph_delta != '0 && longint'(ph_delta) <= 2 * MAX_STEP));

  a_r8_preset_level: assert property (@(posedge clk) disable iff (rst)
    (mod_en && !preset_sel) |=> (sample_out == ($past(tx_data) ? AMP_W'(127) : AMP_W'(-127))));

  a_r9_audio_pass: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> sample_out == $past(audio_in));

endmodule

bind msk_tx_mod msk_tx_mod_chk #(
  .ACC_W(ACC_W),
  .AMP_W(AMP_W),
  .MAX_STEP(longint'(SPACE_F))
) u_chk (
  .clk(clk),
  .rst(rst),
  .mod_en(mod_en),
  .preset_sel(preset_sel),
  .tx_data(tx_data),
  .audio_in(audio_in),
  .tx_clk(tx_clk),
  .sample_out(sample_out),
  .phase_acc(phase_acc)
);

// File: tb/msk_tx_mod_test.sv
module msk_tx_mod_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 48;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_sel = 1'b1, rate_sel = 1'b1, sin_sel = 1'b1;
  logic preset_sel = 1'b1, mod_en = 1'b1, tx_data = 1'b1;
  logic signed [7:0] audio_in = '0;
  logic tx_clk;
  logic signed [7:0] sample_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  msk_tx_mod #(.BASE_PERIOD(P)) uut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .rate_sel(rate_sel),
    .sin_sel(sin_sel), .preset_sel(preset_sel), .mod_en(mod_en),
    .tx_data(tx_data), .audio_in(audio_in), .tx_clk(tx_clk),
    .sample_out(sample_out)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  int m_cnt, m_samp, m_since;
  bit m_hold, m_cur, m_wrap_prev, m_was_rst;
  bit m_tag_wrap, m_mod, m_pre;
  logic [23:0] m_base, m_acc;

  function automatic int sine8(int idx);
    int t, u, m;
    t = idx % 128;
    u = t * (128 - t);
    m = (508 * u) / (20480 - u);
    return (idx < 128) ? m : -m;
  endfunction

  function automatic int period_now();
    return (clk_sel && !rate_sel) ? 2 * P : P;
  endfunction

  function automatic logic [23:0] step_of(bit b, int n);
    return b ? 24'((16777216 + n / 2) / n) : 24'((25165824 + n / 2) / n);
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int n;
    n = period_now();
    m_was_rst = rst;
    m_mod = mod_en;
    m_pre = preset_sel;
    m_tag_wrap = m_wrap_prev;
    if (rst) begin
      m_cnt = 0; m_hold = 1; m_cur = 1;
      m_base = sin_sel ? 24'd0 : 24'h400000;
      m_acc = m_base; m_samp = 0; m_since = 0; m_wrap_prev = 0;
    end else begin
      m_since++;
      m_samp = !mod_en ? int'(audio_in) : (!preset_sel ? (tx_data ? 127 : -127) : sine8(int'(m_acc[23:16])));
      if (m_cnt == n / 2 - 1) m_hold = tx_data;
      if (m_cnt >= n - 1) begin
        m_base = m_base + (m_cur ? 24'd0 : 24'h800000);
        m_acc = m_base;
        m_cur = m_hold;
        m_cnt = 0;
        m_wrap_prev = 1;
      end else begin
        m_acc = m_acc + step_of(m_cur, n);
        m_cnt++;
        m_wrap_prev = 0;
      end
    end
  endtask

  task automatic cycle();
    string tag;
    int n;
    model_step();
    @(negedge clk);
    n = period_now();
    check(m_was_rst ? "R1 tx_clk" : "R2 tx_clk", int'(tx_clk), (m_cnt >= n / 2) ? 1 : 0);
    if (m_was_rst) tag = "R1 sample";
    else if (!m_mod) tag = "R9 audio";
    else if (!m_pre) tag = "R8 preset";
    else if (m_since == 1) tag = "R7 start phase";
    else if (m_tag_wrap) tag = "R3 R5 boundary";
    else tag = "R4 R6 waveform";
    check(tag, int'(sample_out), m_samp);
  endtask

  task automatic do_reset(bit s, bit cs, bit rs);
    rst = 1; sin_sel = s; clk_sel = cs; rate_sel = rs;
    mod_en = 1; preset_sel = 1; tx_data = 1;
    repeat (3) cycle();
    rst = 0;
  endtask

  task automatic run_random(int cycles);
    for (int i = 0; i < cycles; i++) begin
      if ($urandom % 8 == 0) tx_data = 1'($urandom);
      if ($urandom % 300 == 0) mod_en = !mod_en;
      if ($urandom % 250 == 0) preset_sel = !preset_sel;
      audio_in = 8'($urandom);
      cycle();
    end
    mod_en = 1; preset_sel = 1;
  endtask

  task automatic run_pattern(logic [15:0] pat);
    for (int b = 0; b < 16; b++) begin
      tx_data = pat[b];
      for (int c = 0; c < period_now(); c++) cycle();
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL R2 watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset(1, 1, 1);
    run_pattern(16'hFFFF);
    run_pattern(16'h0000);
    run_pattern(16'h5555);
    run_random(1500);
    do_reset(0, 1, 0);
    run_pattern(16'h00FF);
    run_random(2000);
    do_reset(1, 0, 0);
    run_random(1500);
    do_reset(0, 0, 1);
    run_pattern(16'hA5C3);
    mod_en = 0;
    for (int i = 0; i < 100; i++) begin audio_in = 8'($urandom); cycle(); end
    mod_en = 1; preset_sel = 0;
    for (int i = 0; i < 100; i++) begin tx_data = 1'($urandom); cycle(); end
    preset_sel = 1;
    run_random(1000);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule